// File: doc/BRIEF.md
# Frozen-Angle Byte Readout

This block sits between the up/down position counter of a tracking angle converter and a host that reads the angle over a narrow 8-bit bus. An output latch normally follows the counter word cycle by cycle. When the host pulls the active-low hold input low, the latch keeps its value so the host can read a coherent angle, while the counter behind it goes on tracking. The latch never loads while the counter signals that an update is in progress. If the hold request arrives during such an update, the latch waits for the update to finish, loads the settled word once and then freezes, so the host never sees a half-updated angle.

The host reads the latched angle one byte at a time through two active-low byte selects. One select puts the upper eight angle bits on the bus. The other puts the lower byte on the bus. In coarse (14-bit) mode the two least significant lines of the lower byte read as zero. If neither select is active, the output-enable is low and the bus lines are driven to zero. Data follows a select change after one registered cycle, which stands in for the analog access and release times.

Top module: `angle_readout`

## Requirements
- R1: After reset, busOe is 0, busOut is 0 and the latched angle is 0. A byte read taken before any load returns 0.
- R2: While holdN is 1 and busyIn is 0, the latch loads angleIn on every rising clock edge.
- R3: If holdN is 0 and busyIn is 0 at a rising edge while the latch is tracking, the latch loads angleIn at that edge and then keeps that value. Later changes on angleIn do not alter what the bus returns while holdN stays 0.
- R4: The latch never loads on an edge where busyIn is 1. If holdN falls during busy, the latch loads the first word seen with busyIn at 0 and then freezes.
- R5: One edge after selHiN is sampled at 0, busOe is 1 and busOut equals latched angle bits [15:8]. The angle's most significant bit appears on busOut[7].
- R6: One edge after selLoN is sampled at 0 with selHiN at 1, busOut carries the lower byte. With fine16 at 1 this is latched bits [7:0]. With fine16 at 0 it is latched bits [7:2] on busOut[7:2], and busOut[1:0] is 0.
- R7: When selHiN and selLoN are both 0, the upper byte is driven.
- R8: One edge after both selects are sampled at 1, busOe is 0 and busOut is 0.
- R9: On the first edge where holdN is 1 again, with busyIn at 0, the latch resumes loading angleIn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| angleIn | input | 16 | Counter angle word, MSB first (bit 15 = half turn) |
| busyIn | input | 1 | Counter update in progress |
| holdN | input | 1 | Active-low freeze of the output latch |
| selHiN | input | 1 | Active-low select of the upper byte |
| selLoN | input | 1 | Active-low select of the lower byte |
| fine16 | input | 1 | 1 = 16-bit resolution, 0 = 14-bit |
| busOut | output | 8 | Byte bus data |
| busOe | output | 1 | Bus output-enable (0 = high impedance) |

## Verification
The hardest case to reach is a hold request that lands during a counter update. The latch must then wait out the busy pulse and capture only the first settled word after it. The stimulus lowers holdN in the same cycle that raises busyIn, and changes angleIn twice while busy stays high. It then drops busy with a third word and changes the angle once more before reading. Only the third word may appear on both bytes.

// File: rtl/angle_readout_pkg.sv
package angle_readout_pkg;
  typedef enum logic [1:0] {
    ST_TRACK  = 2'd0,
    ST_PEND   = 2'd1,
    ST_FROZEN = 2'd2
  } latchState_t;

  typedef struct packed {
    logic loadAngle;
    logic driveHi;
    logic driveLo;
  } pathStrobe_t;
endpackage

// File: rtl/angle_readout_ctrl.sv
module angle_readout_ctrl
  import angle_readout_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busyIn,
  input  logic        holdN,
  input  logic        selHiN,
  input  logic        selLoN,
  output pathStrobe_t strobe,
  output logic        frozen
);
  latchState_t state, stateNxt;
  logic loadNow;

  always_comb begin
    stateNxt = state;
    loadNow  = 1'b0;
    if (holdN) begin
      stateNxt = ST_TRACK;
      loadNow  = !busyIn;
    end else begin
      case (state)
        ST_TRACK, ST_PEND: begin
          if (busyIn) stateNxt = ST_PEND;
          else begin
            stateNxt = ST_FROZEN;
            loadNow  = 1'b1;
          end
        end
        default: stateNxt = ST_FROZEN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_TRACK;
    else       state <= stateNxt;
  end

  // upper byte wins when both selects are low
  always_comb begin
    strobe.loadAngle = loadNow;
    strobe.driveHi   = !selHiN;
    strobe.driveLo   = selHiN && !selLoN;
  end

  assign frozen = (state == ST_FROZEN);
endmodule

// File: rtl/angle_readout_path.sv
module angle_readout_path
  import angle_readout_pkg::*;
#(
  parameter int ANGLE_W  = 16,
  parameter int COARSE_W = 14,
  parameter int BUS_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pathStrobe_t        strobe,
  input  logic [ANGLE_W-1:0] angleIn,
  input  logic               fine16,
  output logic [ANGLE_W-1:0] heldAngle,
  output logic [BUS_W-1:0]   busOut,
  output logic               busOe
);
  localparam int PAD_W = ANGLE_W - COARSE_W;

  logic [BUS_W-1:0] hiByte, loFull, loByte, busNxt;

  assign hiByte = heldAngle[ANGLE_W-1 -: BUS_W];
  assign loFull = heldAngle[BUS_W-1:0];

  generate
    if (PAD_W > 0) begin : g_pad
      assign loByte = fine16 ? loFull : {loFull[BUS_W-1:PAD_W], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign loByte = loFull;
    end
  endgenerate

  always_comb begin
    busNxt = '0;
    if (strobe.driveHi)      busNxt = hiByte;
    else if (strobe.driveLo) busNxt = loByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAngle <= '0;
      busOut    <= '0;
      busOe     <= 1'b0;
    end else begin
      if (strobe.loadAngle) heldAngle <= angleIn;
      busOut <= busNxt;
      busOe  <= strobe.driveHi || strobe.driveLo;
    end
  end
endmodule

// File: rtl/angle_readout.sv
module angle_readout
  import angle_readout_pkg::*;
#(
  parameter int ANGLE_W  = 16,
  parameter int COARSE_W = 14,
  parameter int BUS_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ANGLE_W-1:0] angleIn,
  input  logic               busyIn,
  input  logic               holdN,
  input  logic               selHiN,
  input  logic               selLoN,
  input  logic               fine16,
  output logic [BUS_W-1:0]   busOut,
  output logic               busOe
);
  pathStrobe_t        strobe;
  logic               frozen;
  logic [ANGLE_W-1:0] heldAngle;

  angle_readout_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .holdN(holdN),
    .selHiN(selHiN), .selLoN(selLoN), .strobe(strobe), .frozen(frozen)
  );

  angle_readout_path #(.ANGLE_W(ANGLE_W), .COARSE_W(COARSE_W), .BUS_W(BUS_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .angleIn(angleIn), .fine16(fine16),
    .heldAngle(heldAngle), .busOut(busOut), .busOe(busOe)
  );
endmodule

// File: rtl/angle_readout_chk.sv
module angle_readout_chk #(
  parameter int ANGLE_W  = 16,
  parameter int COARSE_W = 14,
  parameter int BUS_W    = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [ANGLE_W-1:0] angleIn,
  input logic               busyIn,
  input logic               holdN,
  input logic               selHiN,
  input logic               selLoN,
  input logic               fine16,
  input logic [BUS_W-1:0]   busOut,
  input logic               busOe,
  input logic [ANGLE_W-1:0] heldAngle,
  input logic               frozen
);
  localparam int PAD_W = ANGLE_W - COARSE_W;

  p_track_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (holdN && !busyIn) |=> heldAngle == $past(angleIn));

  p_frozen_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !holdN) |=> $stable(heldAngle));

  p_no_tear_r4: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> $stable(heldAngle));

  p_hi_byte_r5: assert property (@(posedge clk) disable iff (!rstN)
    !selHiN |=> (busOe && busOut == $past(heldAngle[ANGLE_W-1 -: BUS_W])));

  p_coarse_pad_r6: assert property (@(posedge clk) disable iff (!rstN)
    (selHiN && !selLoN && !fine16) |=> (busOe && busOut[PAD_W-1:0] == '0));

  p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selHiN && selLoN) |=> (!busOe && busOut == '0));
endmodule

bind angle_readout angle_readout_chk #(.ANGLE_W(ANGLE_W), .COARSE_W(COARSE_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .angleIn(angleIn), .busyIn(busyIn), .holdN(holdN),
  .selHiN(selHiN), .selLoN(selLoN), .fine16(fine16), .busOut(busOut), .busOe(busOe),
  .heldAngle(heldAngle), .frozen(frozen)
);

// File: tb/test_angle_readout.sv
module test_angle_readout;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] angleIn = '0;
  logic        busyIn = 1'b0;
  logic        holdN = 1'b1;
  logic        selHiN = 1'b1;
  logic        selLoN = 1'b1;
  logic        fine16 = 1'b1;
  logic [7:0]  busOut;
  logic        busOe;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  angle_readout i_angle_readout (
    .clk(clk), .rstN(rstN), .angleIn(angleIn), .busyIn(busyIn), .holdN(holdN),
    .selHiN(selHiN), .selLoN(selLoN), .fine16(fine16), .busOut(busOut), .busOe(busOe)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readByte(input bit hi, output logic [7:0] b, output logic oe);
    if (hi) selHiN = 1'b0; else selLoN = 1'b0;
    tick();
    b = busOut; oe = busOe;
    selHiN = 1'b1; selLoN = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic t_reset();
    logic [7:0] b; logic oe;
    check("R1 oe", {15'd0, busOe}, 16'd0);
    check("R1 bus", {8'd0, busOut}, 16'd0);
    holdN = 1'b0; angleIn = 16'hFFFF; busyIn = 1'b1; tick();
    readByte(1'b1, b, oe);
    check("R1 held", {8'd0, b}, 16'd0);
    busyIn = 1'b0; holdN = 1'b1; tick();
  endtask

  task automatic t_track();
    logic [7:0] b; logic oe;
    fine16 = 1'b1; angleIn = 16'hA5C3; tick();
    readByte(1'b1, b, oe);
    check("R2 R5 hi", {7'd0, oe, b}, {7'd0, 1'b1, 8'hA5});
    readByte(1'b0, b, oe);
    check("R6 fine lo", {7'd0, oe, b}, {7'd0, 1'b1, 8'hC3});
    fine16 = 1'b0; angleIn = 16'h3C7F; tick();
    readByte(1'b0, b, oe);
    check("R6 coarse lo", {8'd0, b}, 16'h007C);
    readByte(1'b1, b, oe);
    check("R2 new hi", {8'd0, b}, 16'h003C);
    fine16 = 1'b1;
  endtask

  task automatic t_freeze();
    logic [7:0] b; logic oe;
    angleIn = 16'h1234; holdN = 1'b0; tick();
    angleIn = 16'hBEEF; tick(3);
    readByte(1'b1, b, oe);
    check("R3 hi", {8'd0, b}, 16'h0012);
    readByte(1'b0, b, oe);
    check("R3 lo", {8'd0, b}, 16'h0034);
    holdN = 1'b1; tick();
    readByte(1'b1, b, oe);
    check("R9 resume", {8'd0, b}, 16'h00BE);
  endtask

  task automatic t_busy();
    logic [7:0] b; logic oe;
    angleIn = 16'h1111; tick();
    busyIn = 1'b1; angleIn = 16'h2222; holdN = 1'b0; tick();
    angleIn = 16'h3333; tick();
    busyIn = 1'b0; angleIn = 16'h4444; tick();
    angleIn = 16'h5555; tick();
    readByte(1'b1, b, oe);
    check("R4 hi", {8'd0, b}, 16'h0044);
    readByte(1'b0, b, oe);
    check("R4 lo", {8'd0, b}, 16'h0044);
    holdN = 1'b1; angleIn = 16'h6666; tick();
    busyIn = 1'b1; angleIn = 16'h7777; tick(2);
    readByte(1'b1, b, oe);
    check("R4 track busy", {8'd0, b}, 16'h0066);
    busyIn = 1'b0; tick();
  endtask

  task automatic t_bothIdle();
    angleIn = 16'h9A3B; tick();
    selHiN = 1'b0; selLoN = 1'b0; tick();
    check("R7 both", {7'd0, busOe, busOut}, {7'd0, 1'b1, 8'h9A});
    selHiN = 1'b1; selLoN = 1'b1; tick();
    check("R8 oe", {15'd0, busOe}, 16'd0);
    check("R8 bus", {8'd0, busOut}, 16'd0);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();
    t_reset();
    t_track();
    t_freeze();
    t_busy();
    t_bothIdle();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule